// File: doc/BRIEF.md
# Tamper-Protected Backup Register File

This block is a bank of 16-bit data words that must outlive ordinary system resets and wake-ups from low-power states. Only a dedicated domain reset clears it. Software reaches the bank through a small register port with a write strobe and a combinational read path. Writes take effect only while an external write-unlock input is held high. Reads are always allowed.

A tamper pin guards the contents. It is synchronised into the block clock and compared against a programmable active level. When tamper detection is enabled and the pin moves into its active level, every data word is wiped to zero. A sticky status flag records the event, and a one-cycle event pulse is raised. An interrupt output is the flag masked by an interrupt-enable bit. Software clears the flag by writing a one to the status word.

Top module: `bkup_regfile`

## Requirements
- R1: When dom_rst_n_i is asserted low, every data word, the control word and the tamper flag return to zero, and every read returns zero afterwards.
- R2: Asserting sys_rst_n_i low changes no data word, no control bit and no flag.
- R3: A write that arrives while wr_unlock_i is low changes no data word, no control bit and no flag.
- R4: While unlocked, a write to byte address 4*i (i from 0 to NUM_REGS-1) stores bus_wdata_i in word i, and a read of that address returns it.
- R5: Reads of any address that is not a multiple of 4, or that lies above the status word, return zero. Writes to such addresses have no effect.
- R6: The control word sits at byte address 4*NUM_REGS (0xA8 by default). Bit 0 enables tamper detection. Bit 1 selects the active level (0 = high, 1 = low). Bit 2 enables the interrupt. With detection enabled, a transition of tamper_pin_i into the active level clears all data words to zero and sets the flag within 4 clock cycles.
- R7: A pin held at its active level does not trigger again. A transition that occurs while bit 0 of the control word is 0 triggers nothing.
- R8: The status word sits at byte address 4*NUM_REGS+4 (0xAC by default), and the flag reads back in bit 0. The flag stays set until an unlocked write of 1 to bit 0 clears it. A write of 0 to that bit leaves it set.
- R9: tamper_irq_o equals the flag ANDed with control bit 2.
- R10: tamper_evt_o is high for exactly one clock cycle for each detected tamper event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| dom_rst_n_i | input | 1 | Domain reset, active low, asynchronous; clears all state |
| sys_rst_n_i | input | 1 | System reset, active low; resets only the event pulse |
| wr_unlock_i | input | 1 | Write-access gate; writes are ignored while low |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for bus_addr_i |
| tamper_pin_i | input | 1 | Asynchronous tamper input |
| tamper_irq_o | output | 1 | Tamper interrupt (flag and enable) |
| tamper_evt_o | output | 1 | One-cycle pulse per detected event |

## Verification
Several properties are checked on every cycle. The event output never lasts two cycles. The array is already zero in the cycle the event pulse appears. The array never changes while the gate is closed, unless a tamper event hits. The interrupt is only seen with the flag set, and the flag never drops unless a clear write arrives. The bench scenarios are the only way to show the rest. These are the survival of data across a system reset, the full wipe performed by a domain reset, the decoding of word-aligned and unused addresses, the two tamper polarities with their synchroniser latency, and the absence of any retrigger while the pin is held.

// File: rtl/bkup_pkg.sv
package bkup_pkg;

   // control word fields; bit positions are software visible
   localparam int CTL_TEN_BIT = 0;
   localparam int CTL_POL_BIT = 1;
   localparam int CTL_IEN_BIT = 2;
   localparam int CTL_W       = 3;

   typedef struct packed {
      logic irq_en;
      logic pol_low;
      logic tmp_en;
   } ctl_t;

   function automatic ctl_t ctl_from_word(input logic [CTL_W-1:0] w);
      ctl_t c;
      c.tmp_en  = w[CTL_TEN_BIT];
      c.pol_low = w[CTL_POL_BIT];
      c.irq_en  = w[CTL_IEN_BIT];
      return c;
   endfunction

endpackage

// File: rtl/bkup_tamper_det.sv
module bkup_tamper_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic pin_i,
   input  logic pol_low_i,
   input  logic en_i,
   output logic det_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   act_prev_q;
   logic                   active;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bkup_tamper_det: SYNC_STAGES must be at least 2");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_n_i) begin
               if (!rst_n_i) sync_q[0] <= 1'b0;
               else          sync_q[0] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_n_i) begin
               if (!rst_n_i) sync_q[s] <= 1'b0;
               else          sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign active = sync_q[SYNC_STAGES-1] ^ pol_low_i;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) act_prev_q <= 1'b0;
      else          act_prev_q <= active;
   end

   assign det_o = en_i & active & ~act_prev_q;

endmodule

// File: rtl/bkup_store.sv
module bkup_store #(
   parameter int NUM_REGS = 42,
   parameter int DATA_W   = 16,
   localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                       clk_i,
   input  logic                       rst_n_i,
   input  logic                       wipe_i,
   input  logic                       we_i,
   input  logic [IDX_W-1:0]           idx_i,
   input  logic [DATA_W-1:0]          wdata_i,
   output logic [NUM_REGS*DATA_W-1:0] q_flat_o
);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i)
               word_q <= '0;
            else if (wipe_i)
               word_q <= '0;
            else if (we_i && (idx_i == IDX_W'(i)))
               word_q <= wdata_i;
         end
         assign q_flat_o[i*DATA_W +: DATA_W] = word_q;
      end
   endgenerate

endmodule

// File: rtl/bkup_regfile.sv
module bkup_regfile
   import bkup_pkg::*;
#(
   parameter int NUM_REGS    = 42,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              dom_rst_n_i,
   input  logic              sys_rst_n_i,
   input  logic              wr_unlock_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              tamper_pin_i,
   output logic              tamper_irq_o,
   output logic              tamper_evt_o
);

   localparam int WORD_W   = ADDR_W - 2;
   localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam int CTL_WORD = NUM_REGS;
   localparam int STA_WORD = NUM_REGS + 1;

   generate
      if (DATA_W < CTL_W) begin : g_bad_width
         $error("bkup_regfile: DATA_W too narrow for the control word");
      end
      if (ADDR_W < 3 || (STA_WORD >= (1 << WORD_W))) begin : g_bad_addr
         $error("bkup_regfile: ADDR_W too small for NUM_REGS plus two words");
      end
      if (IDX_W > WORD_W) begin : g_bad_idx
         $error("bkup_regfile: index wider than the word address");
      end
   endgenerate

   logic [WORD_W-1:0]          word_addr;
   logic                       aligned;
   logic                       data_hit, ctl_hit, sta_hit;
   logic                       wr_ok;
   logic [IDX_W-1:0]           idx;
   logic [NUM_REGS*DATA_W-1:0] mem_flat;
   ctl_t                       ctl_q;
   logic                       tflag_q;
   logic                       evt_q;
   logic                       tamper_hit;
   logic                       evt_rst_n;

   assign word_addr = bus_addr_i[ADDR_W-1:2];
   assign aligned   = (bus_addr_i[1:0] == 2'b00);
   assign data_hit  = aligned && (word_addr < WORD_W'(NUM_REGS));
   assign ctl_hit   = aligned && (word_addr == WORD_W'(CTL_WORD));
   assign sta_hit   = aligned && (word_addr == WORD_W'(STA_WORD));
   assign idx       = word_addr[IDX_W-1:0];
   assign wr_ok     = bus_wr_i && wr_unlock_i;

   bkup_store #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W)
   ) u_store (
      .clk_i    (clk_i),
      .rst_n_i  (dom_rst_n_i),
      .wipe_i   (tamper_hit),
      .we_i     (wr_ok && data_hit),
      .idx_i    (idx),
      .wdata_i  (bus_wdata_i),
      .q_flat_o (mem_flat)
   );

   bkup_tamper_det #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_det (
      .clk_i     (clk_i),
      .rst_n_i   (dom_rst_n_i),
      .pin_i     (tamper_pin_i),
      .pol_low_i (ctl_q.pol_low),
      .en_i      (ctl_q.tmp_en),
      .det_o     (tamper_hit)
   );

   always_ff @(posedge clk_i or negedge dom_rst_n_i) begin
      if (!dom_rst_n_i)
         ctl_q <= '0;
      else if (wr_ok && ctl_hit)
         ctl_q <= ctl_from_word(bus_wdata_i[CTL_W-1:0]);
   end

   // a detection in the same cycle as a clear write keeps the flag set
   always_ff @(posedge clk_i or negedge dom_rst_n_i) begin
      if (!dom_rst_n_i)
         tflag_q <= 1'b0;
      else if (tamper_hit)
         tflag_q <= 1'b1;
      else if (wr_ok && sta_hit && bus_wdata_i[0])
         tflag_q <= 1'b0;
   end

   assign evt_rst_n = dom_rst_n_i & sys_rst_n_i;

   always_ff @(posedge clk_i or negedge evt_rst_n) begin
      if (!evt_rst_n) evt_q <= 1'b0;
      else            evt_q <= tamper_hit;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (data_hit)
         bus_rdata_o = mem_flat[idx*DATA_W +: DATA_W];
      else if (ctl_hit) begin
         bus_rdata_o[CTL_TEN_BIT] = ctl_q.tmp_en;
         bus_rdata_o[CTL_POL_BIT] = ctl_q.pol_low;
         bus_rdata_o[CTL_IEN_BIT] = ctl_q.irq_en;
      end else if (sta_hit)
         bus_rdata_o[0] = tflag_q;
   end

   assign tamper_irq_o = tflag_q & ctl_q.irq_en;
   assign tamper_evt_o = evt_q;

endmodule

// File: rtl/bkup_chk.sv
module bkup_chk #(
   parameter int NUM_REGS = 42,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 8
) (
   input logic                       clk_i,
   input logic                       dom_rst_n_i,
   input logic                       wr_unlock_i,
   input logic                       bus_wr_i,
   input logic [ADDR_W-1:0]          bus_addr_i,
   input logic [DATA_W-1:0]          bus_wdata_i,
   input logic                       tamper_irq_o,
   input logic                       tamper_evt_o,
   input logic                       tamper_hit,
   input logic                       tflag_q,
   input logic [NUM_REGS*DATA_W-1:0] mem_flat
);

   localparam logic [ADDR_W-1:0] STA_ADDR = ADDR_W'(4 * (NUM_REGS + 1));

   logic clr_wr;
   assign clr_wr = bus_wr_i && wr_unlock_i && (bus_addr_i == STA_ADDR) && bus_wdata_i[0];

   // R10
   evt_single_chk: assert property (@(posedge clk_i) disable iff (!dom_rst_n_i)
      tamper_evt_o |=> !tamper_evt_o);

   // R6
   wipe_done_chk: assert property (@(posedge clk_i) disable iff (!dom_rst_n_i)
      tamper_evt_o |-> (mem_flat == '0));

   // R3
   locked_stable_chk: assert property (@(posedge clk_i) disable iff (!dom_rst_n_i)
      (!wr_unlock_i && !tamper_hit) |=> $stable(mem_flat));

   // R9
   irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!dom_rst_n_i)
      tamper_irq_o |-> tflag_q);

   // R8
   flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!dom_rst_n_i)
      (tflag_q && !clr_wr) |=> tflag_q);

   // R6
   flag_on_hit_chk: assert property (@(posedge clk_i) disable iff (!dom_rst_n_i)
      tamper_hit |=> (tflag_q && tamper_evt_o));

endmodule

bind bkup_regfile bkup_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk_i        (clk_i),
   .dom_rst_n_i  (dom_rst_n_i),
   .wr_unlock_i  (wr_unlock_i),
   .bus_wr_i     (bus_wr_i),
   .bus_addr_i   (bus_addr_i),
   .bus_wdata_i  (bus_wdata_i),
   .tamper_irq_o (tamper_irq_o),
   .tamper_evt_o (tamper_evt_o),
   .tamper_hit   (tamper_hit),
   .tflag_q      (tflag_q),
   .mem_flat     (mem_flat)
);

// File: tb/sim_bkup_regfile.sv
`timescale 1ns/1ps
module sim_bkup_regfile;

   localparam int NR = 42;
   localparam int DW = 16;
   localparam int AW = 8;
   localparam logic [AW-1:0] CTL_A = 8'hA8;
   localparam logic [AW-1:0] STA_A = 8'hAC;

   logic          clk = 1'b0;
   logic          dom_rst_n = 1'b0;
   logic          sys_rst_n = 1'b0;
   logic          unlock = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          pin = 1'b0;
   logic          irq, evt;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] exp_mem [NR];
   logic [2:0]    exp_ctl;
   logic          exp_flag;

   always #4 clk = ~clk;

   bkup_regfile u0 (
      .clk_i(clk), .dom_rst_n_i(dom_rst_n), .sys_rst_n_i(sys_rst_n),
      .wr_unlock_i(unlock), .bus_addr_i(addr), .bus_wr_i(wr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tamper_pin_i(pin),
      .tamper_irq_o(irq), .tamper_evt_o(evt)
   );

   function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
      if (a[1:0] != 2'b00) return '0;
      if (a[AW-1:2] < NR) return exp_mem[a[AW-1:2]];
      if (a == CTL_A) return {13'd0, exp_ctl};
      if (a == STA_A) return {15'd0, exp_flag};
      return '0;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic model_wipe();
      for (int i = 0; i < NR; i++) exp_mem[i] = '0;
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      if (unlock && a[1:0] == 2'b00) begin
         if (a[AW-1:2] < NR) exp_mem[a[AW-1:2]] = d;
         else if (a == CTL_A) exp_ctl = d[2:0];
         else if (a == STA_A && d[0]) exp_flag = 1'b0;
      end
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic read_chk(input string tag, input logic [AW-1:0] a);
      addr = a;
      #1;
      chk(tag, rdata, model_read(a));
   endtask

   task automatic read_all(input string tag);
      for (int i = 0; i < NR; i++) read_chk(tag, AW'(4 * i));
      read_chk(tag, CTL_A);
      read_chk(tag, STA_A);
   endtask

   // drive the pin and count event cycles; returns pulses seen
   task automatic drive_pin(input logic v, output int pulses);
      @(negedge clk);
      pin = v;
      pulses = 0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         if (evt) pulses++;
      end
   endtask

   initial begin : wdog
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int n;
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      model_wipe();
      exp_ctl = '0; exp_flag = 1'b0;
      repeat (3) @(negedge clk);
      dom_rst_n = 1'b1; sys_rst_n = 1'b1;

      // R1: reset state
      read_all("R1 reset");
      chk("R1 irq", {15'd0, irq}, 16'd0);
      chk("R1 evt", {15'd0, evt}, 16'd0);

      // R3: locked writes ignored
      unlock = 1'b0;
      bus_write(8'h00, 16'hDEAD);
      bus_write(CTL_A, 16'h0007);
      read_chk("R3 data", 8'h00);
      read_chk("R3 ctl", CTL_A);

      // R4: directed writes, first and last word
      unlock = 1'b1;
      bus_write(8'h00, 16'h1234);
      bus_write(AW'(4 * (NR - 1)), 16'hBEEF);
      read_chk("R4 first", 8'h00);
      read_chk("R4 last", AW'(4 * (NR - 1)));

      // R5: unaligned and out-of-range
      bus_write(8'h05, 16'hFFFF);
      bus_write(8'hB0, 16'hFFFF);
      read_chk("R5 unaligned", 8'h05);
      read_chk("R5 above", 8'hB0);
      read_chk("R5 neighbour", 8'h04);

      // R4 R5 R3: random mix
      for (int it = 0; it < 400; it++) begin
         logic [AW-1:0] a;
         int sel;
         sel = $urandom_range(0, 9);
         if (sel < 6)      a = AW'(4 * $urandom_range(0, NR - 1));
         else if (sel < 8) a = {6'($urandom_range(0, NR - 1)), 2'($urandom_range(1, 3))};
         else              a = AW'($urandom_range(8'hB0, 8'hFF));
         unlock = ($urandom_range(0, 3) != 0);
         bus_write(a, 16'($urandom));
         read_chk("R4 random", a);
         read_chk("R5 random", AW'($urandom_range(8'hB0, 8'hFF)));
      end
      unlock = 1'b1;
      read_all("R4 sweep");

      // R2: system reset preserves storage
      bus_write(CTL_A, 16'h0004);
      @(negedge clk); sys_rst_n = 1'b0;
      repeat (3) @(negedge clk); sys_rst_n = 1'b1;
      read_all("R2 sysrst");

      // R7: detection disabled -> nothing
      drive_pin(1'b1, n);
      chk("R7 disabled pulses", 16'(n), 16'd0);
      read_chk("R7 data kept", 8'h00);
      drive_pin(1'b0, n);

      // R6: active-high tamper wipes and flags
      bus_write(CTL_A, 16'h0005);
      drive_pin(1'b1, n);
      model_wipe(); exp_flag = 1'b1;
      chk("R10 one pulse", 16'(n), 16'd1);
      read_all("R6 wipe high");
      chk("R9 irq on", {15'd0, irq}, 16'd1);

      // R7: held level does not retrigger
      bus_write(8'h08, 16'hAAAA);
      repeat (6) @(negedge clk);
      read_chk("R7 held", 8'h08);

      // R9: irq masked
      bus_write(CTL_A, 16'h0001);
      chk("R9 irq masked", {15'd0, irq}, 16'd0);

      // R8: sticky flag, write 0, locked clear, then clear
      bus_write(STA_A, 16'h0000);
      read_chk("R8 write0", STA_A);
      unlock = 1'b0;
      bus_write(STA_A, 16'h0001);
      read_chk("R8 locked clear", STA_A);
      unlock = 1'b1;
      bus_write(STA_A, 16'h0001);
      read_chk("R8 cleared", STA_A);

      // R6: active-low polarity; pin currently high, release low
      drive_pin(1'b0, n);  // still enabled, active high: falling edge, no event
      chk("R7 leave active", 16'(n), 16'd0);
      bus_write(8'h10, 16'h5A5A);
      bus_write(CTL_A, 16'h0006);  // low polarity, detection off: pin 0 is active
      drive_pin(1'b1, n);
      bus_write(CTL_A, 16'h0007);
      drive_pin(1'b0, n);
      model_wipe(); exp_flag = 1'b1;
      chk("R10 low pulse", 16'(n), 16'd1);
      read_all("R6 wipe low");
      chk("R9 irq low", {15'd0, irq}, 16'd1);

      // R1: domain reset mid-run
      bus_write(8'h0C, 16'h7777);
      @(negedge clk); dom_rst_n = 1'b0;
      @(negedge clk); dom_rst_n = 1'b1;
      model_wipe(); exp_ctl = '0; exp_flag = 1'b0;
      read_all("R1 domrst");
      chk("R1 irq after", {15'd0, irq}, 16'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule